// File: doc/BRIEF.md
# Variable Pulse Width Symbol Receiver

This block listens to a single-wire variable pulse width bus and turns the timing of its level changes into symbols and bytes. The bus input is synchronized, and every interval between two level changes is measured in ticks of an external 1 µs strobe. The receiver decodes each interval from its length together with the bus level it held: a data bit, a start-of-frame, or an error. A high level on the bus is the active level.

Long passive stretches are detected while they are still running. They mark the end of the data and then the end of the frame. An active stretch that runs too long is a break. Received bytes leave the block with a flag that marks the first byte after a start-of-frame. Separate one-cycle strobes report start-of-message, end-of-data, end-of-frame and invalid symbols. An eight-bit status code records the most recent notable event. A quad-speed enable bit can be loaded from outside. In quad-speed mode every timing limit is divided by four. A break clears the enable bit and leaves its own status code.

Top module: `vpw_symbol_rx`

## Requirements
- R1: The bus input passes two synchronizing flops. An output strobe caused by a bus level change is registered on the third rising clock edge after the change.
- R2: A data bit needs at least 34 ticks and fewer than 164. It is short below 96 ticks and long from 96 on. An active short bit is 0 and an active long bit is 1. A passive short bit is 1 and a passive long bit is 0.
- R3: Bits form bytes most significant bit first. After eight bits, `byte_valid_o` pulses with the byte on `byte_o`. `byte_first_o` is 1 only for the first byte after a start-of-frame.
- R4: An active interval of 164 to 239 ticks is a start-of-frame and pulses `som_o`. It is accepted whenever no byte reception is open, including right after end-of-data, without waiting for an idle gap.
- R5: A passive interval that reaches 200 ticks during reception pulses `eod_o` if it falls on a byte boundary. Otherwise it is an invalid symbol.
- R6: A passive interval that reaches 280 ticks after an accepted start-of-frame pulses `eof_o` once and closes the message.
- R7: An active interval that reaches 240 ticks is a break. It ends the message without `eof_o`. During reception it also pulses `invalid_o`. Outside quad-speed mode it sets status 0x20.
- R8: A break in quad-speed mode sets status 0x1C and clears `x4_en_o`.
- R9: During reception, an interval shorter than 34 ticks, a passive interval of 164 to 199 ticks, or a start-of-frame pulses `invalid_o`. Status becomes 0x24, and later bits are dropped until the next start-of-frame.
- R10: When `x4_en_o` is 1, every timing limit is the normal limit shifted right by two bits: 8, 24, 41, 50, 60 and 70 ticks.
- R11: After reset, all strobes, `byte_o`, `x4_en_o` and `status_o` are 0.
- R12: Status becomes 0x0C when a byte completes and 0x04 on end-of-frame. It changes on no other event than those in R7, R8 and R9.
- R13: Data bits that arrive while no start-of-frame is open produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe every microsecond |
| bus_i | input | 1 | Asynchronous bus level, 1 = active |
| x4_load_i | input | 1 | Load strobe for the quad-speed enable |
| x4_value_i | input | 1 | Value loaded into the quad-speed enable |
| x4_en_o | output | 1 | Quad-speed enable bit |
| byte_o | output | 8 | Last received byte |
| byte_valid_o | output | 1 | Byte strobe |
| byte_first_o | output | 1 | Byte is the first after start-of-frame |
| som_o | output | 1 | Start-of-message strobe |
| eod_o | output | 1 | End-of-data strobe |
| eof_o | output | 1 | End-of-frame strobe |
| invalid_o | output | 1 | Invalid symbol strobe |
| status_o | output | 8 | Last event status code |

## Verification
Results that a bus level change closes are due on the third rising edge after the change: start-of-message, bytes, and invalid symbols caused by timing. The monitor samples on the falling edge and checks that the gap between the driver's last bus change and the strobe is exactly three cycles. End-of-data, end-of-frame and break results come from timeouts inside a running interval, so they are checked for order and content only. The driver queues each of those expectations before the interval that produces it starts. Status and the quad-speed bit are read after the whole interval has elapsed, long after any update is due.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;

    localparam int CNT_W  = 10;
    localparam int BYTE_W = 8;
    localparam int STAT_W = 8;
    localparam int X4_SHIFT = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t LIM_BIT_MIN = cnt_t'(34);
    localparam cnt_t LIM_BIT_MID = cnt_t'(96);
    localparam cnt_t LIM_BIT_MAX = cnt_t'(164);
    localparam cnt_t LIM_EOD     = cnt_t'(200);
    localparam cnt_t LIM_EOF     = cnt_t'(280);
    localparam cnt_t LIM_BRK     = cnt_t'(240);

    typedef struct packed {
        cnt_t bit_min;
        cnt_t bit_mid;
        cnt_t bit_max;
        cnt_t eod;
        cnt_t eof;
        cnt_t brk;
    } limits_t;

    typedef enum logic [1:0] {
        SYM_NONE,
        SYM_BIT,
        SYM_SOF,
        SYM_BAD
    } sym_kind_e;

    typedef struct packed {
        sym_kind_e kind;
        logic      value;
    } sym_t;

    localparam logic [STAT_W-1:0] ST_NONE   = 8'h00;
    localparam logic [STAT_W-1:0] ST_EOF    = 8'h04;
    localparam logic [STAT_W-1:0] ST_BYTE   = 8'h0C;
    localparam logic [STAT_W-1:0] ST_BRK4X  = 8'h1C;
    localparam logic [STAT_W-1:0] ST_BRK    = 8'h20;
    localparam logic [STAT_W-1:0] ST_INVAL  = 8'h24;

    function automatic limits_t get_limits(input logic x4);
        limits_t l;
        l.bit_min = LIM_BIT_MIN;
        l.bit_mid = LIM_BIT_MID;
        l.bit_max = LIM_BIT_MAX;
        l.eod     = LIM_EOD;
        l.eof     = LIM_EOF;
        l.brk     = LIM_BRK;
        if (x4) begin
            l.bit_min = l.bit_min >> X4_SHIFT;
            l.bit_mid = l.bit_mid >> X4_SHIFT;
            l.bit_max = l.bit_max >> X4_SHIFT;
            l.eod     = l.eod     >> X4_SHIFT;
            l.eof     = l.eof     >> X4_SHIFT;
            l.brk     = l.brk     >> X4_SHIFT;
        end
        return l;
    endfunction

    // Decode one closed interval from its length and the level it held.
    function automatic sym_t classify(input logic active, input cnt_t len,
                                      input limits_t l);
        sym_t s;
        logic is_long;
        s.kind  = SYM_NONE;
        s.value = 1'b0;
        is_long = (len >= l.bit_mid);
        if (len < l.bit_min) begin
            s.kind = SYM_BAD;
        end else if (len < l.bit_max) begin
            s.kind  = SYM_BIT;
            s.value = active ? is_long : !is_long;
        end else if (active) begin
            s.kind = (len < l.brk) ? SYM_SOF : SYM_NONE;
        end else begin
            s.kind = (len < l.eod) ? SYM_BAD : SYM_NONE;
        end
        return s;
    endfunction

endpackage

// File: rtl/vpw_edge_sync.sv
module vpw_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_i,
    output logic level_o,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], bus_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign edge_o  = sync_q[STAGES-1] ^ last_q;
    assign level_o = last_q;

    // R1
    edge_flips_level_chk: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> (level_o != $past(level_o)));

endmodule

// File: rtl/vpw_interval_timer.sv
module vpw_interval_timer
    import vpw_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick_i,
    input  logic    edge_i,
    input  logic    level_i,
    input  limits_t lim_i,
    output cnt_t    count_o,
    output logic    spent_o,
    output logic    eod_hit_o,
    output logic    eof_hit_o,
    output logic    brk_hit_o
);
    localparam cnt_t CNT_MAX = '1;

    cnt_t count_q;
    logic spent_q;
    logic advance;

    assign advance   = tick_i && !edge_i;
    assign eod_hit_o = advance && !level_i && (count_q == lim_i.eod - cnt_t'(1));
    assign eof_hit_o = advance && !level_i && (count_q == lim_i.eof - cnt_t'(1));
    assign brk_hit_o = advance &&  level_i && (count_q == lim_i.brk - cnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            spent_q <= 1'b0;
        end else if (edge_i) begin
            count_q <= '0;
            spent_q <= 1'b0;
        end else begin
            if (tick_i && count_q != CNT_MAX) begin
                count_q <= count_q + cnt_t'(1);
            end
            if (eod_hit_o || brk_hit_o) begin
                spent_q <= 1'b1;
            end
        end
    end

    assign count_o = count_q;
    assign spent_o = spent_q;

    // R1
    count_restart_chk: assert property (@(posedge clk) disable iff (rst)
        edge_i |=> (count_o == '0 && !spent_o));

    // R5
    eod_once_chk: assert property (@(posedge clk) disable iff (rst)
        eod_hit_o |=> !eod_hit_o);

    // R7
    brk_spends_chk: assert property (@(posedge clk) disable iff (rst)
        brk_hit_o |=> spent_o);

endmodule

// File: rtl/vpw_frame_assembler.sv
module vpw_frame_assembler
    import vpw_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sym_t              sym_i,
    input  logic              eod_hit_i,
    input  logic              eof_hit_i,
    input  logic              brk_hit_i,
    input  logic              x4_load_i,
    input  logic              x4_value_i,
    output logic              x4_en_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_valid_o,
    output logic              byte_first_o,
    output logic              som_o,
    output logic              eod_o,
    output logic              eof_o,
    output logic              invalid_o,
    output logic [STAT_W-1:0] status_o
);
    localparam int BC_W = $clog2(BYTE_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_W - 1);

    logic              in_frame_q;
    logic              msg_open_q;
    logic              first_q;
    logic [BC_W-1:0]   bit_cnt_q;
    logic [BYTE_W-1:0] shift_q;
    logic [BYTE_W-1:0] shift_nx;

    assign shift_nx = {shift_q[BYTE_W-2:0], sym_i.value};

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q   <= 1'b0;
            msg_open_q   <= 1'b0;
            first_q      <= 1'b0;
            bit_cnt_q    <= '0;
            shift_q      <= '0;
            x4_en_o      <= 1'b0;
            byte_o       <= '0;
            byte_valid_o <= 1'b0;
            byte_first_o <= 1'b0;
            som_o        <= 1'b0;
            eod_o        <= 1'b0;
            eof_o        <= 1'b0;
            invalid_o    <= 1'b0;
            status_o     <= ST_NONE;
        end else begin
            byte_valid_o <= 1'b0;
            som_o        <= 1'b0;
            eod_o        <= 1'b0;
            eof_o        <= 1'b0;
            invalid_o    <= 1'b0;
            if (brk_hit_i) begin
                invalid_o  <= in_frame_q;
                in_frame_q <= 1'b0;
                msg_open_q <= 1'b0;
                if (x4_en_o) begin
                    x4_en_o  <= 1'b0;
                    status_o <= ST_BRK4X;
                end else begin
                    status_o <= ST_BRK;
                end
            end else begin
                if (x4_load_i) begin
                    x4_en_o <= x4_value_i;
                end
                if (eod_hit_i && in_frame_q) begin
                    in_frame_q <= 1'b0;
                    if (bit_cnt_q == '0) begin
                        eod_o <= 1'b1;
                    end else begin
                        invalid_o  <= 1'b1;
                        msg_open_q <= 1'b0;
                        status_o   <= ST_INVAL;
                    end
                end
                if (eof_hit_i && msg_open_q) begin
                    eof_o      <= 1'b1;
                    msg_open_q <= 1'b0;
                    status_o   <= ST_EOF;
                end
                unique case (sym_i.kind)
                    SYM_SOF: begin
                        if (in_frame_q) begin
                            invalid_o  <= 1'b1;
                            in_frame_q <= 1'b0;
                            msg_open_q <= 1'b0;
                            status_o   <= ST_INVAL;
                        end else begin
                            som_o      <= 1'b1;
                            in_frame_q <= 1'b1;
                            msg_open_q <= 1'b1;
                            first_q    <= 1'b1;
                            bit_cnt_q  <= '0;
                        end
                    end
                    SYM_BIT: begin
                        if (in_frame_q) begin
                            shift_q   <= shift_nx;
                            bit_cnt_q <= bit_cnt_q + BC_W'(1);
                            if (bit_cnt_q == LAST_BIT) begin
                                byte_valid_o <= 1'b1;
                                byte_o       <= shift_nx;
                                byte_first_o <= first_q;
                                first_q      <= 1'b0;
                                status_o     <= ST_BYTE;
                            end
                        end
                    end
                    SYM_BAD: begin
                        if (in_frame_q) begin
                            invalid_o  <= 1'b1;
                            in_frame_q <= 1'b0;
                            msg_open_q <= 1'b0;
                            status_o   <= ST_INVAL;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8
    brk_quad_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_hit_i && x4_en_o) |=> (!x4_en_o && status_o == ST_BRK4X));

    // R6
    eof_needs_msg_chk: assert property (@(posedge clk) disable iff (rst)
        eof_o |-> $past(msg_open_q));

    // R3
    byte_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |-> $past(in_frame_q));

    // R9
    byte_not_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        !(byte_valid_o && invalid_o));

endmodule

// File: rtl/vpw_symbol_rx.sv
module vpw_symbol_rx
    import vpw_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        bus_i,
    input  logic        x4_load_i,
    input  logic        x4_value_i,
    output logic        x4_en_o,
    output logic [7:0]  byte_o,
    output logic        byte_valid_o,
    output logic        byte_first_o,
    output logic        som_o,
    output logic        eod_o,
    output logic        eof_o,
    output logic        invalid_o,
    output logic [7:0]  status_o
);
    logic    level;
    logic    edge_det;
    cnt_t    count;
    logic    spent;
    logic    eod_hit;
    logic    eof_hit;
    logic    brk_hit;
    limits_t lim;
    sym_t    sym;

    assign lim = get_limits(x4_en_o);

    vpw_edge_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .bus_i   (bus_i),
        .level_o (level),
        .edge_o  (edge_det)
    );

    vpw_interval_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .edge_i    (edge_det),
        .level_i   (level),
        .lim_i     (lim),
        .count_o   (count),
        .spent_o   (spent),
        .eod_hit_o (eod_hit),
        .eof_hit_o (eof_hit),
        .brk_hit_o (brk_hit)
    );

    always_comb begin
        sym = '{kind: SYM_NONE, value: 1'b0};
        if (edge_det && !spent) begin
            sym = classify(level, count, lim);
        end
    end

    vpw_frame_assembler u_frame (
        .clk          (clk),
        .rst          (rst),
        .sym_i        (sym),
        .eod_hit_i    (eod_hit),
        .eof_hit_i    (eof_hit),
        .brk_hit_i    (brk_hit),
        .x4_load_i    (x4_load_i),
        .x4_value_i   (x4_value_i),
        .x4_en_o      (x4_en_o),
        .byte_o       (byte_o),
        .byte_valid_o (byte_valid_o),
        .byte_first_o (byte_first_o),
        .som_o        (som_o),
        .eod_o        (eod_o),
        .eof_o        (eof_o),
        .invalid_o    (invalid_o),
        .status_o     (status_o)
    );

    // R13
    no_output_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (som_o || byte_valid_o) |-> $past(edge_det));

endmodule

// File: tb/test_vpw_symbol_rx.sv
module test_vpw_symbol_rx;

    localparam int TDIV = 4;
    localparam int EV_SOM = 0, EV_BYTE = 1, EV_EOD = 2, EV_EOF = 3, EV_INV = 4;

    typedef struct {
        int          kind;
        logic [7:0]  data;
        logic        first;
        bit          lat;
        string       req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic bus = 1'b0;
    logic x4_load = 1'b0;
    logic x4_value = 1'b0;
    logic       x4_en;
    logic [7:0] byte_d;
    logic       byte_v, byte_f, som, eod, eof, inv;
    logic [7:0] status;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc = 0;
    int last_chg = 0;
    int tdiv_cnt = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
        tick <= (tdiv_cnt == TDIV - 1);
    end

    vpw_symbol_rx i_vpw_symbol_rx (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .bus_i        (bus),
        .x4_load_i    (x4_load),
        .x4_value_i   (x4_value),
        .x4_en_o      (x4_en),
        .byte_o       (byte_d),
        .byte_valid_o (byte_v),
        .byte_first_o (byte_f),
        .som_o        (som),
        .eod_o        (eod),
        .eof_o        (eof),
        .invalid_o    (inv),
        .status_o     (status)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input logic [7:0] data,
                             input logic first, input bit lat, input string req);
        exp_t e;
        e.kind = kind; e.data = data; e.first = first; e.lat = lat; e.req = req;
        q.push_back(e);
    endtask

    task automatic drive(input logic lvl, input int us);
        @(negedge clk);
        bus = lvl;
        last_chg = cyc;
        repeat (us * TDIV - 1) @(negedge clk);
    endtask

    // R2 R3: bit levels alternate, first bit of a byte is passive
    task automatic send_byte(input logic [7:0] b, input bit quad, input logic first);
        int s_len = quad ? 16 : 64;
        int l_len = quad ? 32 : 128;
        expect_ev(EV_BYTE, b, first, 1'b1, "R3");
        for (int i = 7; i >= 0; i--) begin
            logic act = (i % 2 == 0);
            logic v = b[i];
            int len = act ? (v ? l_len : s_len) : (v ? s_len : l_len);
            drive(act, len);
        end
    endtask

    task automatic send_sof(input bit quad);
        expect_ev(EV_SOM, 8'h00, 1'b0, 1'b1, "R4");
        drive(1'b1, quad ? 50 : 200);
    endtask

    // Monitor: pop and compare every strobe as it appears.
    task automatic pop_cmp(input int kind, input logic [7:0] data, input logic first);
        exp_t e;
        if (q.size() == 0) begin
            check("R13 unexpected event", kind, -1);
            return;
        end
        e = q.pop_front();
        check({e.req, " kind"}, kind, e.kind);
        if (e.kind == EV_BYTE && kind == EV_BYTE) begin
            check({e.req, " data"}, data, e.data);
            check({e.req, " first"}, first, e.first);
        end
        if (e.lat) check("R1 latency", cyc - last_chg, 3);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (som)    pop_cmp(EV_SOM, 8'h00, 1'b0);
            if (byte_v) pop_cmp(EV_BYTE, byte_d, byte_f);
            if (eod)    pop_cmp(EV_EOD, 8'h00, 1'b0);
            if (eof)    pop_cmp(EV_EOF, 8'h00, 1'b0);
            if (inv)    pop_cmp(EV_INV, 8'h00, 1'b0);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R11 reset state
        check("R11 strobes", {byte_v, byte_f, som, eod, eof, inv}, 0);
        check("R11 byte", byte_d, 0);
        check("R11 status", status, 0);
        check("R11 x4", x4_en, 0);
        rst = 1'b0;

        // R13 bits with no open frame
        drive(1'b0, 300);
        drive(1'b1, 64);
        drive(1'b0, 64);
        drive(1'b1, 128);
        drive(1'b0, 300);
        check("R13 status untouched", status, 8'h00);

        // R2 R3 R5 R6 two-byte message
        send_sof(1'b0);
        send_byte(8'hA5, 1'b0, 1'b1);
        send_byte(8'h3C, 1'b0, 1'b0);
        expect_ev(EV_EOD, 8'h00, 1'b0, 1'b0, "R5");
        expect_ev(EV_EOF, 8'h00, 1'b0, 1'b0, "R6");
        drive(1'b0, 300);
        check("R12 status eof", status, 8'h04);

        // R4 new SOF right after EOD, no idle gap
        send_sof(1'b0);
        send_byte(8'h81, 1'b0, 1'b1);
        expect_ev(EV_EOD, 8'h00, 1'b0, 1'b0, "R5");
        drive(1'b0, 220);
        send_sof(1'b0);
        send_byte(8'h7E, 1'b0, 1'b1);
        expect_ev(EV_EOD, 8'h00, 1'b0, 1'b0, "R5");
        expect_ev(EV_EOF, 8'h00, 1'b0, 1'b0, "R6");
        drive(1'b0, 300);

        // R9 active pulse too short
        send_sof(1'b0);
        drive(1'b0, 64);
        expect_ev(EV_INV, 8'h00, 1'b0, 1'b1, "R9");
        drive(1'b1, 20);
        drive(1'b0, 300);
        check("R9 status invalid", status, 8'h24);

        // R5 EOD inside a byte is invalid
        send_sof(1'b0);
        drive(1'b0, 64);
        drive(1'b1, 64);
        drive(1'b0, 128);
        drive(1'b1, 128);
        expect_ev(EV_INV, 8'h00, 1'b0, 1'b0, "R5");
        drive(1'b0, 300);

        // R9 SOF in the middle of a byte
        send_sof(1'b0);
        drive(1'b0, 64);
        drive(1'b1, 200);
        expect_ev(EV_INV, 8'h00, 1'b0, 1'b1, "R9");
        drive(1'b0, 300);

        // R7 break during reception
        send_sof(1'b0);
        send_byte(8'h55, 1'b0, 1'b1);
        drive(1'b0, 64);
        check("R12 status byte", status, 8'h0C);
        expect_ev(EV_INV, 8'h00, 1'b0, 1'b0, "R7");
        drive(1'b1, 300);
        drive(1'b0, 300);
        check("R7 status break", status, 8'h20);

        // R10 quad-speed message
        @(negedge clk);
        x4_load = 1'b1; x4_value = 1'b1;
        @(negedge clk);
        x4_load = 1'b0;
        check("R10 x4 set", x4_en, 1);
        send_sof(1'b1);
        send_byte(8'hC3, 1'b1, 1'b1);
        expect_ev(EV_EOD, 8'h00, 1'b0, 1'b0, "R10");
        expect_ev(EV_EOF, 8'h00, 1'b0, 1'b0, "R10");
        drive(1'b0, 80);

        // R8 break in quad-speed mode
        send_sof(1'b1);
        drive(1'b0, 16);
        expect_ev(EV_INV, 8'h00, 1'b0, 1'b0, "R8");
        drive(1'b1, 80);
        drive(1'b0, 300);
        check("R8 status", status, 8'h1C);
        check("R8 x4 cleared", x4_en, 0);

        repeat (10) @(negedge clk);
        check("R13 queue drained", q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule